// File: doc/BRIEF.md
# Retry-Aware Bus Data Tenure Controller

This block sits on the master side of a split-transaction processor bus. Each transfer-start strobe places a read or write data tenure into a small pending queue. A data bus grant from the system arbiter moves the selected pending tenure onto the data bus, where it runs for a fixed number of acknowledged beats. A data-retry input holds a beat in place without advancing the burst.

The block also decides what an address-retry snoop response does to data traffic. Only the most recently started address tenure is under snoop. Its response window opens a programmable number of cycles after its strobe, and a retry counts only in that opening cycle. Depending on where the tenure stands at that moment, the retry does one of three things:
- it withdraws the tenure from the queue;
- it disqualifies a grant given in that same cycle;
- it aborts the running tenure and invalidates its late beats.

Acknowledges that arrive too early to be cancelled are flagged as protocol errors.

Top module: `bus_tenure_ctl`

## Requirements
- R1: After reset, the data bus is idle (`dbusy_o` low), the queue is empty (`pend_o` = 0), and `beat_ok_o`, `abort_o`, `proto_err_o` and `drop_o` are all zero.
- R2: A strobe on `ts_i` appends a tenure to the queue (write when `ts_wr_i` = 1, read when 0). `pend_o` reports the number of queued tenures from the next cycle on. The count never exceeds DEPTH.
- R3: A grant is qualified when `dgrant_i` is high, the bus is idle and the queue is not empty. It removes the chosen tenure and raises `dbusy_o` from the next cycle. The chosen tenure is the oldest entry, or the oldest write when `wr_first_i` is high and a write is queued. `act_wr_o` gives the type of the running tenure.
- R4: While `dbusy_o` is high, `ta_i` with `dretry_i` low accepts a beat (`beat_ok_o`). `ta_i` with `dretry_i` high accepts nothing and does not advance the burst. `dbusy_o` falls the cycle after the BEATS-th accepted beat.
- R5: The snoop window of a tenure starts `max(2, win_ofs_i)` cycles after its strobe cycle. A later strobe moves the snoop to the new tenure.
- R6: `mode_i` selects the mode: 00 normal, 01 streaming, 10 fast-cache, 11 treated as normal. For the tenure under snoop, an accepted beat earlier than window start minus one (normal) or earlier than window start (streaming, fast-cache) raises `proto_err_o` in that cycle.
- R7: A qualified retry on the running snooped tenure pulses `abort_o`, suppresses `beat_ok_o` for a coincident beat, and drops `dbusy_o` in the next cycle, even mid-burst. `drop_o` gives the number of beats invalidated: one for a beat in the cycle before the window, plus one for a beat in the window cycle.
- R8: A qualified retry on a still-queued snooped tenure removes it from the queue, so no data tenure is ever started for it.
- R9: A qualified retry in the same cycle as a grant that selects the snooped tenure disqualifies the grant. `dbusy_o` stays low in the next cycle even if other tenures are queued. A grant in that next cycle starts the next selected tenure.
- R10: An address retry outside the window start cycle has no effect on the queue or on the data bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ts_i | input | 1 | Transfer-start strobe, enqueues a tenure |
| ts_wr_i | input | 1 | Type of the starting tenure, 1 = write |
| mode_i | input | 2 | 00 normal, 01 streaming, 10 fast-cache |
| win_ofs_i | input | OFS_W | Snoop window start offset in cycles (minimum 2 applied) |
| aretry_i | input | 1 | Address retry snoop response |
| dgrant_i | input | 1 | Data bus grant |
| wr_first_i | input | 1 | Serve the oldest write first on this grant |
| ta_i | input | 1 | Transfer acknowledge for the current beat |
| dretry_i | input | 1 | Data retry, holds the current beat |
| dbusy_o | output | 1 | Data bus busy, a tenure is running |
| act_wr_o | output | 1 | Running tenure is a write |
| beat_ok_o | output | 1 | A beat is accepted this cycle |
| drop_o | output | 2 | Number of beats invalidated by a retry this cycle |
| abort_o | output | 1 | Running tenure aborted by retry |
| proto_err_o | output | 1 | Beat acknowledged too early to be cancellable |
| pend_o | output | clog2(DEPTH+1) | Number of queued tenures |

## Verification
The bound checker enforces, on every cycle:
- the busy signal rises only after a grant;
- no beat is accepted under data retry;
- every abort or beat drop is caused by an address retry, and the bus is released after an abort;
- the queue count stays in bounds and grows by at most one per cycle;
- protocol errors occur only on acknowledged beats.

Only the directed scenarios can show the cycle position effects:
- which beats a retry invalidates;
- where the window opens for a given offset and mode;
- that a disqualified out-of-order write grant leaves the bus idle for a cycle before the older read is served;
- that retries outside the window change nothing.

// File: rtl/bus_tenure_ctl.sv
module bus_tenure_ctl #(
  parameter int DEPTH = 4,
  parameter int BEATS = 4,
  parameter int OFS_W = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ts_i,
  input  logic                       ts_wr_i,
  input  logic [1:0]                 mode_i,
  input  logic [OFS_W-1:0]           win_ofs_i,
  input  logic                       aretry_i,
  input  logic                       dgrant_i,
  input  logic                       wr_first_i,
  input  logic                       ta_i,
  input  logic                       dretry_i,
  output logic                       dbusy_o,
  output logic                       act_wr_o,
  output logic                       beat_ok_o,
  output logic [1:0]                 drop_o,
  output logic                       abort_o,
  output logic                       proto_err_o,
  output logic [$clog2(DEPTH+1)-1:0] pend_o
);
  localparam int IW = $clog2(DEPTH);
  localparam int TW = IW + 2;
  localparam int CW = $clog2(DEPTH+1);
  localparam int BW = $clog2(BEATS+1);

  logic [DEPTH-1:0] q_v, q_w, n_v, n_w;
  logic [TW-1:0]    q_t [DEPTH];
  logic [TW-1:0]    n_t [DEPTH];
  logic [TW-1:0]    next_tag, snp_tag, act_tag;
  logic             snp_act, act, act_w, kill_prev;
  logic [OFS_W-1:0] snp_cnt, win, first_ok;
  logic [BW-1:0]    beats_left;
  logic [IW-1:0]    sel;
  logic             rty, act_snp, beat, sel_snp, gnt;

  assign win      = (win_ofs_i < OFS_W'(2)) ? OFS_W'(2) : win_ofs_i;
  assign first_ok = (mode_i == 2'b01 || mode_i == 2'b10) ? win : win - 1'b1;
  assign rty      = aretry_i && snp_act && (snp_cnt == win);
  assign act_snp  = act && snp_act && (act_tag == snp_tag);
  assign beat     = act && ta_i && !dretry_i;

  assign abort_o     = rty && act_snp;
  assign beat_ok_o   = beat && !abort_o;
  assign drop_o      = {1'b0, rty && kill_prev} + {1'b0, beat && abort_o};
  assign proto_err_o = beat && act_snp && (snp_cnt < first_ok);
  assign dbusy_o     = act;
  assign act_wr_o    = act_w;
  assign pend_o      = CW'($countones(q_v));

  always_comb begin
    logic found;
    found = 1'b0;
    sel   = '0;
    if (wr_first_i)
      for (int i = 0; i < DEPTH; i++)
        if (!found && q_v[i] && q_w[i]) begin
          sel   = IW'(i);
          found = 1'b1;
        end
  end

  assign sel_snp = rty && q_v[sel] && (q_t[sel] == snp_tag);
  assign gnt     = dgrant_i && !act && q_v[0] && !sel_snp;

  always_comb begin
    int k;
    k   = 0;
    n_v = '0;
    n_w = '0;
    for (int i = 0; i < DEPTH; i++) n_t[i] = '0;
    for (int i = 0; i < DEPTH; i++)
      if (q_v[i] && !(rty && q_t[i] == snp_tag) && !(gnt && IW'(i) == sel)) begin
        n_v[IW'(k)] = 1'b1;
        n_w[IW'(k)] = q_w[i];
        n_t[IW'(k)] = q_t[i];
        k++;
      end
    if (ts_i && k < DEPTH) begin
      n_v[IW'(k)] = 1'b1;
      n_w[IW'(k)] = ts_wr_i;
      n_t[IW'(k)] = next_tag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_v        <= '0;
      q_w        <= '0;
      for (int i = 0; i < DEPTH; i++) q_t[i] <= '0;
      next_tag   <= '0;
      snp_act    <= 1'b0;
      snp_cnt    <= '0;
      snp_tag    <= '0;
      act        <= 1'b0;
      act_w      <= 1'b0;
      act_tag    <= '0;
      beats_left <= '0;
      kill_prev  <= 1'b0;
    end else begin
      q_v <= n_v;
      q_w <= n_w;
      for (int i = 0; i < DEPTH; i++) q_t[i] <= n_t[i];
      kill_prev <= beat && act_snp && (snp_cnt == win - 1'b1);
      if (ts_i) begin
        snp_act  <= 1'b1;
        snp_cnt  <= OFS_W'(1);
        snp_tag  <= next_tag;
        next_tag <= next_tag + 1'b1;
      end else if (snp_act) begin
        if (snp_cnt == win) snp_act <= 1'b0;
        else                snp_cnt <= snp_cnt + 1'b1;
      end
      if (gnt) begin
        act        <= 1'b1;
        act_w      <= q_w[sel];
        act_tag    <= q_t[sel];
        beats_left <= BW'(BEATS);
      end else if (act) begin
        if (abort_o) act <= 1'b0;
        else if (beat) begin
          beats_left <= beats_left - 1'b1;
          if (beats_left == BW'(1)) act <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/bus_tenure_ctl_chk.sv
module bus_tenure_ctl_chk #(
  parameter int DEPTH = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       ts_i,
  input logic                       aretry_i,
  input logic                       dgrant_i,
  input logic                       ta_i,
  input logic                       dretry_i,
  input logic                       dbusy_o,
  input logic                       beat_ok_o,
  input logic [1:0]                 drop_o,
  input logic                       abort_o,
  input logic                       proto_err_o,
  input logic [$clog2(DEPTH+1)-1:0] pend_o
);
  AST_BUSY_FROM_GRANT: assert property (@(posedge clk) disable iff (!rst_n) $rose(dbusy_o) |-> $past(dgrant_i)); // R3
  AST_NO_BEAT_ON_DRETRY: assert property (@(posedge clk) disable iff (!rst_n) dretry_i |-> !beat_ok_o); // R4
  AST_BEAT_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n) beat_ok_o |-> (dbusy_o && ta_i)); // R4
  AST_ABORT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) abort_o |-> (aretry_i && dbusy_o)); // R7
  AST_ABORT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) abort_o |=> !dbusy_o); // R7
  AST_DROP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) (drop_o != 2'd0) |-> aretry_i); // R7
  AST_ERR_ON_BEAT: assert property (@(posedge clk) disable iff (!rst_n) proto_err_o |-> (ta_i && dbusy_o)); // R6
  AST_PEND_BOUND: assert property (@(posedge clk) disable iff (!rst_n) pend_o <= DEPTH); // R2
  AST_PEND_STEP: assert property (@(posedge clk) disable iff (!rst_n) !$past(ts_i) |-> (pend_o <= $past(pend_o))); // R2
endmodule

bind bus_tenure_ctl bus_tenure_ctl_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .ts_i(ts_i), .aretry_i(aretry_i), .dgrant_i(dgrant_i),
  .ta_i(ta_i), .dretry_i(dretry_i), .dbusy_o(dbusy_o), .beat_ok_o(beat_ok_o),
  .drop_o(drop_o), .abort_o(abort_o), .proto_err_o(proto_err_o), .pend_o(pend_o)
);

// File: tb/bus_tenure_ctl_tb_top.sv
`timescale 1ns/1ps
module bus_tenure_ctl_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ts_i, ts_wr_i, aretry_i, dgrant_i, wr_first_i, ta_i, dretry_i;
  logic [1:0] mode_i;
  logic [3:0] win_ofs_i;
  logic dbusy_o, act_wr_o, beat_ok_o, abort_o, proto_err_o;
  logic [1:0] drop_o;
  logic [2:0] pend_o;
  int errors = 0, checks = 0;

  always #2.5 clk = ~clk;

  bus_tenure_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .ts_i(ts_i), .ts_wr_i(ts_wr_i), .mode_i(mode_i),
    .win_ofs_i(win_ofs_i), .aretry_i(aretry_i), .dgrant_i(dgrant_i), .wr_first_i(wr_first_i),
    .ta_i(ta_i), .dretry_i(dretry_i), .dbusy_o(dbusy_o), .act_wr_o(act_wr_o),
    .beat_ok_o(beat_ok_o), .drop_o(drop_o), .abort_o(abort_o), .proto_err_o(proto_err_o),
    .pend_o(pend_o)
  );

  task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", what, got, exp, $time);
    end
  endtask

  task automatic clr();
    ts_i = 0; ts_wr_i = 0; aretry_i = 0; dgrant_i = 0; wr_first_i = 0; ta_i = 0; dretry_i = 0;
  endtask

  task automatic nx();
    @(negedge clk);
    clr();
  endtask

  task automatic rst(input logic [1:0] m, input logic [3:0] w);
    rst_n = 0; clr(); mode_i = m; win_ofs_i = w;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic t_reset();
    rst(2'b00, 4'd3); #1;
    chk("R1 dbusy", dbusy_o, 0);
    chk("R1 pend", pend_o, 0);
    chk("R1 pulses", {beat_ok_o, abort_o, proto_err_o, drop_o}, 0);
  endtask

  task automatic t_normal_burst();
    rst(2'b00, 4'd3);
    ts_i = 1; #1;
    nx(); #1; chk("R2 pend after ts", pend_o, 1); chk("R3 idle before grant", dbusy_o, 0);
    dgrant_i = 1;
    nx(); ta_i = 1; #1;
    chk("R3 busy after grant", dbusy_o, 1); chk("R3 dequeued", pend_o, 0); chk("R3 read type", act_wr_o, 0);
    chk("R4 beat 1", beat_ok_o, 1); chk("R6 normal win-1 legal", proto_err_o, 0);
    for (int c = 0; c < 3; c++) begin
      nx(); ta_i = 1; #1; chk("R4 beat", beat_ok_o, 1);
    end
    chk("R4 busy on last beat", dbusy_o, 1);
    nx(); #1; chk("R4 busy ends after last beat", dbusy_o, 0);
  endtask

  task automatic t_dretry();
    rst(2'b00, 4'd2);
    ts_i = 1;
    nx(); nx(); nx(); dgrant_i = 1;
    nx(); ta_i = 1; #1; chk("R4 first beat", beat_ok_o, 1);
    nx(); ta_i = 1; dretry_i = 1; #1; chk("R4 dretry holds beat", beat_ok_o, 0);
    for (int c = 0; c < 3; c++) begin nx(); ta_i = 1; end
    #1; chk("R4 busy on held-out last beat", dbusy_o, 1);
    nx(); #1; chk("R4 busy ends", dbusy_o, 0);
  endtask

  task automatic t_abort();
    rst(2'b00, 4'd3);
    ts_i = 1;
    nx(); dgrant_i = 1;
    nx(); ta_i = 1; #1; chk("R7 pre-window beat", beat_ok_o, 1);
    nx(); ta_i = 1; aretry_i = 1; #1;
    chk("R7 abort", abort_o, 1); chk("R7 beat suppressed", beat_ok_o, 0); chk("R7 drop two", drop_o, 2);
    nx(); #1; chk("R7 burst cut short", dbusy_o, 0); chk("R7 queue empty", pend_o, 0);
  endtask

  task automatic t_fast_drop();
    rst(2'b10, 4'd3);
    ts_i = 1;
    nx(); dgrant_i = 1;
    nx(); ta_i = 1; #1; chk("R6 fast early ack", proto_err_o, 1);
    nx(); aretry_i = 1; #1; chk("R7 abort fast", abort_o, 1); chk("R7 drop one", drop_o, 1);
    nx(); #1; chk("R7 released", dbusy_o, 0);
  endtask

  task automatic t_proto();
    rst(2'b01, 4'd4);
    ts_i = 1;
    nx(); dgrant_i = 1;
    nx();
    nx(); ta_i = 1; #1; chk("R6 streaming win-1 illegal", proto_err_o, 1);
    nx(); ta_i = 1; #1; chk("R6 streaming window ok", proto_err_o, 0);
    nx(); ta_i = 1; nx(); ta_i = 1;
    nx(); #1; chk("R4 stream done", dbusy_o, 0);
    rst(2'b00, 4'd4);
    ts_i = 1;
    nx(); dgrant_i = 1;
    nx(); ta_i = 1; #1; chk("R6 normal win-2 illegal", proto_err_o, 1);
    nx(); ta_i = 1; #1; chk("R6 normal win-1 legal", proto_err_o, 0);
    nx(); ta_i = 1; nx(); ta_i = 1;
    nx(); #1; chk("R4 normal done", dbusy_o, 0);
  endtask

  task automatic t_window_min();
    rst(2'b00, 4'd0);
    ts_i = 1;
    nx(); aretry_i = 1;
    nx(); #1; chk("R10 early retry ignored", pend_o, 1);
    aretry_i = 1;
    nx(); #1; chk("R5 window at 2 with offset 0", pend_o, 0);
  endtask

  task automatic t_retry_queued();
    rst(2'b00, 4'd3);
    ts_i = 1;
    nx(); nx(); aretry_i = 1;
    nx(); #1; chk("R10 retry before window ignored", pend_o, 1);
    aretry_i = 1;
    nx(); #1; chk("R8 withdrawn", pend_o, 0);
    dgrant_i = 1;
    nx(); #1; chk("R8 no tenure after withdraw", dbusy_o, 0);
    nx(); nx(); aretry_i = 1;
    nx(); #1; chk("R10 late retry no effect", dbusy_o, 0);
  endtask

  task automatic t_retry_grant();
    rst(2'b00, 4'd2);
    ts_i = 1;
    nx(); nx();
    nx(); ts_i = 1; ts_wr_i = 1;
    nx(); #1; chk("R2 two pending", pend_o, 2);
    nx(); dgrant_i = 1; wr_first_i = 1; aretry_i = 1; #1;
    chk("R9 no abort on grant retry", abort_o, 0);
    nx(); #1; chk("R9 grant disqualified", dbusy_o, 0); chk("R9 read kept", pend_o, 1);
    dgrant_i = 1;
    nx(); #1; chk("R9 next grant taken", dbusy_o, 1); chk("R9 serves read", act_wr_o, 0);
    chk("R9 queue drained", pend_o, 0);
    for (int c = 0; c < 4; c++) begin ta_i = 1; nx(); end
    #1; chk("R4 read done", dbusy_o, 0);
  endtask

  task automatic t_reorder();
    rst(2'b00, 4'd2);
    ts_i = 1;
    nx(); ts_i = 1; ts_wr_i = 1;
    nx(); #1; chk("R2 two queued", pend_o, 2);
    nx(); nx(); dgrant_i = 1; wr_first_i = 1;
    nx(); #1; chk("R3 write first", act_wr_o, 1); chk("R3 busy", dbusy_o, 1); chk("R3 one left", pend_o, 1);
    for (int c = 0; c < 4; c++) begin ta_i = 1; nx(); end
    #1; chk("R4 write done", dbusy_o, 0);
    dgrant_i = 1;
    nx(); #1; chk("R3 read next", act_wr_o, 0); chk("R3 busy read", dbusy_o, 1);
    for (int c = 0; c < 4; c++) begin ta_i = 1; nx(); end
    #1; chk("R3 all drained", pend_o, 0);
  endtask

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    clr(); mode_i = 0; win_ofs_i = 3;
    t_reset();
    t_normal_burst();
    t_dretry();
    t_abort();
    t_fast_drop();
    t_proto();
    t_window_min();
    t_retry_queued();
    t_retry_grant();
    t_reorder();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule